// File: doc/BRIEF.md
# Staged-Select Crosspoint Switch

This block is a non-blocking crosspoint with 34 single-bit data inputs and 34 single-bit data outputs. Every output has its own 34-way multiplexer, steered by an entry in an active selection bank. The data path holds no registers and needs no data clock, so each output follows its selected input combinationally. Any number of outputs may take the same input.

A host reaches the block through a small parallel port with an address, write data, write and read strobes, and registered read data. A write to a selection address changes only a shadow copy of that output's selection. Outputs can be staged one at a time and in any order. A write of any value to the command address copies the whole shadow bank into the active bank on one clock edge, so a complete new routing takes effect at once. The host can read back the active selections and a flag that shows whether staged changes are still waiting.

Top module: `xbar_switch`

## Requirements
- R1: After reset, output N is routed from input N, both banks hold N in entry N, and reading address N returns N.
- R2: A valid write to address A (0 to 33) with data D (below 34) updates only the shadow entry for output A. The routing and the value read back from address A do not change until a commit.
- R3: A write of any data value to address 34 copies every shadow entry into the active bank on that clock edge, and all outputs switch together.
- R4: One input may drive any number of outputs at once.
- R5: Each output equals the input named by its active entry, combinationally, with no clock edge between an input change and the output change.
- R6: A selection write whose data is 34 or higher is ignored: the shadow and active entries both keep their previous values.
- R7: Reading address 35 returns 1 in bit 0 (all other bits 0) while any shadow entry differs from its active entry, and 0 otherwise.
- R8: Read data is registered. The value for the address present with the read strobe appears on rdata after that clock edge and is held until the next read. Addresses 34 and 36 to 63 read as 0.
- R9: Writes to addresses 35 to 63 have no effect on either bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 6 | Register address for reads and writes |
| wdata | input | 6 | Write data (input index for selection writes) |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| rd_en | input | 1 | Read strobe, sampled on the rising clock edge |
| rdata | output | 6 | Registered read data |
| din | input | 34 | Data inputs, bit i is input i |
| dout | output | 34 | Data outputs, bit o is output o |

## Verification
A corrupted shadow entry does not show on the outputs until the next commit. It appears at once on the pending flag read, and after the commit it shows as one misrouted output. A corrupted active entry misroutes its output at once and also reads back wrong on the next read of that address. The bench therefore checks the pending flag and the readback after each staging step as well as the routing, so a bank error is caught within one read cycle rather than only after a commit.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  // True when an index names a real port of a bank of size n.
  function automatic logic idx_ok(input logic [7:0] idx, input int unsigned n);
    return int'(idx) < int'(n);
  endfunction

endpackage

// File: rtl/xbar_port_dec.sv
module xbar_port_dec #(
  parameter int N_IN   = 34,
  parameter int N_OUT  = 34,
  parameter int ADDR_W = 6,
  parameter int SEL_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEL_W-1:0]  wdata,
  input  logic              wr_en,
  output logic              sel_we,
  output logic              commit
);
  import xbar_pkg::*;

  localparam int CMD_ADDR = N_OUT;

  logic addr_is_sel;
  logic data_ok;

  always_comb begin
    addr_is_sel = idx_ok(8'(addr), N_OUT);
    data_ok     = idx_ok(8'(wdata), N_IN);
    sel_we      = wr_en && addr_is_sel && data_ok;
    commit      = wr_en && (int'(addr) == CMD_ADDR);
  end

endmodule

// File: rtl/xbar_cfg_bank.sv
module xbar_cfg_bank #(
  parameter int N_IN   = 34,
  parameter int N_OUT  = 34,
  parameter int ADDR_W = 6,
  parameter int SEL_W  = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sel_we,
  input  logic [ADDR_W-1:0]           sel_idx,
  input  logic [SEL_W-1:0]            wdata,
  input  logic                        commit,
  output logic [N_OUT-1:0][SEL_W-1:0] shd_q,
  output logic [N_OUT-1:0][SEL_W-1:0] act_q,
  output logic                        pending
);
  import xbar_pkg::*;

  logic [N_OUT-1:0] diff;

  for (genvar g = 0; g < N_OUT; g++) begin : g_ent
    logic [SEL_W-1:0] shd_r;
    logic [SEL_W-1:0] act_r;
    logic             hit;

    assign hit = sel_we && (int'(sel_idx) == g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_r <= SEL_W'(g);
      end else if (hit) begin
        shd_r <= wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_r <= SEL_W'(g);
      end else if (commit) begin
        act_r <= shd_r;
      end
    end

    assign shd_q[g] = shd_r;
    assign act_q[g] = act_r;
    assign diff[g]  = (shd_r != act_r);
  end

  assign pending = |diff;

  logic act_all_ok;
  always_comb begin
    act_all_ok = 1'b1;
    for (int i = 0; i < N_OUT; i++) begin
      if (!idx_ok(8'(act_q[i]), N_IN)) act_all_ok = 1'b0;
    end
  end

  // R2: without a commit the active bank never moves
  p_act_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(act_q));

  // R3: a commit lands the whole shadow bank in one edge
  p_commit_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (act_q == $past(shd_q)));

  // R6: active entries always name a real input
  p_act_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_all_ok);

  // R7: a commit with no simultaneous staging leaves nothing pending
  p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !sel_we) |=> !pending);

endmodule

// File: rtl/xbar_mux_array.sv
module xbar_mux_array #(
  parameter int N_IN  = 34,
  parameter int N_OUT = 34,
  parameter int SEL_W = 6
) (
  input  logic [N_IN-1:0]             din,
  input  logic [N_OUT-1:0][SEL_W-1:0] sel,
  output logic [N_OUT-1:0]            dout
);
  import xbar_pkg::*;

  for (genvar g = 0; g < N_OUT; g++) begin : g_mux
    always_comb begin
      dout[g] = 1'b0;
      for (int i = 0; i < N_IN; i++) begin
        if (int'(sel[g]) == i) dout[g] = din[i];
      end
    end
  end

endmodule

// File: rtl/xbar_switch.sv
module xbar_switch #(
  parameter int N_IN   = 34,
  parameter int N_OUT  = 34,
  parameter int SEL_W  = $clog2(N_IN),
  parameter int ADDR_W = $clog2(N_OUT + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEL_W-1:0]  wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [SEL_W-1:0]  rdata,
  input  logic [N_IN-1:0]   din,
  output logic [N_OUT-1:0]  dout
);
  import xbar_pkg::*;

  localparam int PEND_ADDR = N_OUT + 1;

  logic                        sel_we;
  logic                        commit;
  logic                        pending;
  logic [N_OUT-1:0][SEL_W-1:0] shd_q;
  logic [N_OUT-1:0][SEL_W-1:0] act_q;
  logic [SEL_W-1:0]            rd_val;

  xbar_port_dec #(.N_IN(N_IN), .N_OUT(N_OUT), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_dec (
    .addr   (addr),
    .wdata  (wdata),
    .wr_en  (wr_en),
    .sel_we (sel_we),
    .commit (commit)
  );

  xbar_cfg_bank #(.N_IN(N_IN), .N_OUT(N_OUT), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_we  (sel_we),
    .sel_idx (addr),
    .wdata   (wdata),
    .commit  (commit),
    .shd_q   (shd_q),
    .act_q   (act_q),
    .pending (pending)
  );

  xbar_mux_array #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W)) u_mux (
    .din  (din),
    .sel  (act_q),
    .dout (dout)
  );

  always_comb begin
    rd_val = '0;
    if (idx_ok(8'(addr), N_OUT)) begin
      for (int i = 0; i < N_OUT; i++) begin
        if (int'(addr) == i) rd_val = act_q[i];
      end
    end else if (int'(addr) == PEND_ADDR) begin
      rd_val = SEL_W'(pending);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_val;
    end
  end

  // R6, R9: rejected writes leave the shadow bank untouched
  p_reject_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_we && !commit) |=> $stable(shd_q));

  // R8: read data only moves on a read strobe
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: tb/tb_xbar_switch.sv
module tb_xbar_switch;
  localparam int NI = 34;
  localparam int NO = 34;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic [5:0]  wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  rdata;
  logic [NI-1:0] din = '0;
  logic [NO-1:0] dout;

  xbar_switch dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .din(din), .dout(dout)
  );

  always #10 clk = ~clk;

  typedef struct {
    bit          is_rd;
    logic [33:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  event  go;
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  int act_m[NO];
  int shd_m[NO];

  function automatic logic [33:0] route_m();
    logic [33:0] r;
    for (int o = 0; o < NO; o++) r[o] = din[act_m[o]];
    return r;
  endfunction

  function automatic int pend_m();
    for (int o = 0; o < NO; o++) if (act_m[o] != shd_m[o]) return 1;
    return 0;
  endfunction

  // monitor: pops one expected item per trigger and compares
  initial begin
    forever begin
      item_t it;
      logic [33:0] got;
      @(go);
      #1;
      it = sbq.pop_front();
      got = it.is_rd ? {28'b0, rdata} : dout;
      checks++;
      if (got !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, got, it.exp);
      end
    end
  end

  task automatic push(input bit is_rd, input logic [33:0] e, input string tag);
    item_t it;
    it.is_rd = is_rd; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    ->go;
    #2;
  endtask

  task automatic chk_route(input string tag);
    push(1'b0, route_m(), tag);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 6'(a); wdata = 6'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == NO) begin
      for (int o = 0; o < NO; o++) act_m[o] = shd_m[o];
    end else if (a < NO && d < NI) begin
      shd_m[a] = d;
    end
  endtask

  task automatic rd(input int a, input string tag);
    logic [33:0] e;
    @(negedge clk);
    addr = 6'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    if (a < NO) e = 34'(act_m[a]);
    else if (a == NO + 1) e = 34'(pend_m());
    else e = '0;
    push(1'b1, e, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int o = 0; o < NO; o++) begin act_m[o] = o; shd_m[o] = o; end
    din = 34'h2_5A5A_F00F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset routing and readback
    chk_route("R1 reset identity route");
    din = 34'h1_0F0F_33CC;
    chk_route("R1 reset identity route b");
    rd(0, "R1 read addr 0");
    rd(17, "R1 read addr 17");
    rd(33, "R1 read addr 33");
    rd(35, "R7 pending after reset");

    // R5 combinational path, no clock edge between change and check
    @(posedge clk); #3;
    din = ~din;
    #2;
    chk_route("R5 comb follow");

    // R2 staging only
    wr(5, 7);
    wr(6, 0);
    chk_route("R2 route unchanged while staged");
    rd(5, "R2 readback still active");
    rd(35, "R7 pending set");

    // R3 commit
    wr(34, 0);
    chk_route("R3 route after commit");
    rd(5, "R3 read addr 5");
    rd(6, "R3 read addr 6");
    rd(35, "R7 pending cleared");

    // R4 fan-out of input 3
    for (int o = 10; o <= 20; o++) wr(o, 3);
    wr(34, 63);
    din = 34'h0_0000_0008;
    chk_route("R4 fanout high");
    din = 34'h3_FFFF_FFF7;
    chk_route("R4 fanout low");

    // R6 invalid indices
    wr(2, 34);
    wr(3, 63);
    rd(35, "R6 no pending after bad writes");
    wr(34, 0);
    rd(2, "R6 entry 2 kept");
    rd(3, "R6 entry 3 kept");
    chk_route("R6 route kept");

    // R9 writes to non-selection addresses
    wr(35, 1);
    wr(40, 1);
    wr(63, 0);
    rd(35, "R9 no pending after stray writes");
    chk_route("R9 route kept");

    // R8 unmapped reads and hold
    rd(34, "R8 cmd addr reads 0");
    rd(50, "R8 unmapped read 0");
    rd(33, "R8 read addr 33");
    @(negedge clk); addr = 6'd0;
    @(negedge clk);
    push(1'b1, 34'(act_m[33]), "R8 rdata held");

    // R2/R3 full reversal staged then committed
    for (int o = 0; o < NO; o++) wr(o, NO - 1 - o);
    chk_route("R2 reversal staged");
    rd(35, "R7 pending with reversal");
    wr(34, 5);
    din = 34'h2_AAAA_5555;
    chk_route("R3 reversal a");
    din = 34'h1_2345_6789;
    chk_route("R3 reversal b");
    rd(0, "R3 read addr 0 reversed");
    rd(33, "R3 read addr 33 reversed");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule